// File: doc/BRIEF.md
# Complex NCO Digital Mixer

This block shifts a chosen carrier in a real sampled signal down to 0 Hz. A 16-bit phase accumulator advances by a programmable tuning word on every valid input sample. Its phase selects a cosine and sine pair from a quarter-wave amplitude table. Each real sample is multiplied by that pair, which gives an in-phase (I) and quadrature (Q) output. The oscillator sequence is e^(jθn) with θ = 2π·tuning/65536, so the tuning resolution is one part in 65536 of the sample rate. A tuning word of 49152 (-fs/4) moves a carrier that sits at +fs/4 down to zero.

A second path mixes with a fixed quarter-rate tone, +fs/4 or -fs/4. That path uses only sign changes and an I/Q swap, and has no multiplier. A frequency-shift mode runs the programmable oscillator but forces both outputs to zero when the tuning word sits exactly on ±fs/4. That tuning is not legal in this mode. The decimation filters that follow the mixer and any real-output conversion sit outside this block.

Top module: `cplx_nco_mixer`

## Requirements
- R1: A synchronous active-high reset clears the phase to zero and drives `o_valid`, `o_i` and `o_q` to zero. The first valid sample after reset is mixed at phase 0, so I ≈ x·2047/512 and Q ≈ 0.
- R2: `o_valid` is high exactly in the cycle after the third rising clock edge, counted from the edge that samples `i_valid` high. It is low for every other cycle.
- R3: In modes 1 and 3 (programmable oscillator), I = round(x·C/512) and Q = round(x·S/512). C and S are 2047·cos θ and 2047·sin θ, rounded to integers. θ is 2π/1024 times the top 10 bits of the phase at which the sample is taken.
- R4: The phase advances modulo 65536 by one step per valid sample and never moves on cycles where `i_valid` is low. In modes 1, 2 and 3 the step is `i_ftw`. Sample n after reset uses the phase that n steps have built up.
- R5: A new `i_ftw` value takes effect from the next valid sample. The phase reached so far is kept and not reset.
- R6: In mode 0 the coefficient depends only on phase bits [15:14]: 0 gives (1,0), 1 gives (0,1), 2 gives (-1,0) and 3 gives (0,-1). The sample, shifted left by two, is multiplied by this coefficient. The step is 49152 (-fs/4) when `i_quarter_up` is 0 and 16384 (+fs/4) when it is 1.
- R7: In mode 2 a tuning word of 16384 or 49152 forces I and Q to zero while `o_valid` still follows R2 and the phase still advances. Any other tuning word in mode 2 gives the R3 result.
- R8: An output outside the signed 16-bit range saturates to 32767 or -32768. For example, mode 0 with x = -8192 and coefficient -1 gives 32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | Input sample strobe |
| i_sample | input | 14 | Signed real input sample |
| i_ftw | input | 16 | Oscillator tuning word |
| i_mode | input | 2 | 0 quarter-rate, 1 oscillator, 2 frequency-shift with guard, 3 oscillator |
| i_quarter_up | input | 1 | Quarter-rate direction: 1 is +fs/4, 0 is -fs/4 |
| o_valid | output | 1 | Output sample strobe |
| o_i | output | 16 | Signed in-phase output |
| o_q | output | 16 | Signed quadrature output |

## Verification
A zero tuning word with a few extreme samples separates a correct start-up phase and gain from scaling or I/Q swap faults. Long random runs mix random tuning words, valid gaps and tuning changes in the middle of a stream, and they are compared with a reference oscillator that advances only on valid samples. These runs expose phase steps taken during idle cycles, phase resets when the tuning word changes, and sign errors in the quarter-wave table mirroring. Quarter-rate runs in both directions check the sign and swap sequence, and full-scale negative samples there drive the saturation. Frequency-shift runs at both forbidden words and at one word just next to them check that zeroing is exact and that the phase keeps advancing underneath.

// File: rtl/cnm_pkg.sv
package cnm_pkg;

    typedef enum logic [1:0] {
        MIX_QUARTER = 2'd0,
        MIX_NCO     = 2'd1,
        MIX_SHIFT   = 2'd2,
        MIX_NCO_ALT = 2'd3
    } mix_mode_e;

    // Rounded amp * sin(pi/2 * k / 2^lut_bits), evaluated with Q30 integer
    // Taylor terms up to the eleventh power; used only at elaboration.
    function automatic int quarter_sine(input int k, input int lut_bits, input int amp);
        longint a;
        longint t;
        longint s;
        longint r;
        a = (64'sd3373259426 * longint'(k)) >>> (lut_bits + 1);
        t = a;
        s = a;
        for (int i = 1; i <= 5; i++) begin
            t = (t * a) >>> 30;
            t = (t * a) >>> 30;
            t = -t / longint'((2 * i) * (2 * i + 1));
            s = s + t;
        end
        r = (s * longint'(amp) + (64'sd1 <<< 29)) >>> 30;
        return int'(r);
    endfunction

endpackage

// File: rtl/cnm_phase_acc.sv
module cnm_phase_acc #(
    parameter int DW = 14,
    parameter int PW = 16,
    parameter int PB = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_valid,
    input  logic signed [DW-1:0] i_sample,
    input  logic [PW-1:0]        i_ftw,
    input  logic [1:0]           i_mode,
    input  logic                 i_quarter_up,
    output logic                 a_valid,
    output logic signed [DW-1:0] a_sample,
    output logic [PB-1:0]        a_phase,
    output logic                 a_quarter,
    output logic                 a_zero
);
    import cnm_pkg::*;

    localparam logic [PW-1:0] QTR  = PW'(1) << (PW - 2);
    localparam logic [PW-1:0] TQTR = QTR + (QTR << 1);

    typedef struct packed {
        logic [PW-1:0]        acc;
        logic                 valid;
        logic signed [DW-1:0] sample;
        logic [PB-1:0]        phase;
        logic                 quarter;
        logic                 zero;
    } acc_st_t;

    acc_st_t st_d, st_q;
    mix_mode_e mode;
    logic [PW-1:0] step;

    always_comb begin
        mode  = mix_mode_e'(i_mode);
        step  = i_ftw;
        if (mode == MIX_QUARTER) begin
            step = i_quarter_up ? QTR : TQTR;
        end
        st_d       = st_q;
        st_d.valid = i_valid;
        if (i_valid) begin
            st_d.sample  = i_sample;
            st_d.phase   = st_q.acc[PW-1 -: PB];
            st_d.quarter = (mode == MIX_QUARTER);
            st_d.zero    = (mode == MIX_SHIFT) && ((i_ftw == QTR) || (i_ftw == TQTR));
            st_d.acc     = st_q.acc + step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_valid   = st_q.valid;
    assign a_sample  = st_q.sample;
    assign a_phase   = st_q.phase;
    assign a_quarter = st_q.quarter;
    assign a_zero    = st_q.zero;

    // R4
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(i_valid) && !$past(rst)) |-> $stable(st_q.acc));

endmodule

// File: rtl/cnm_sincos.sv
module cnm_sincos #(
    parameter int DW = 14,
    parameter int AW = 12,
    parameter int LB = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 a_valid,
    input  logic signed [DW-1:0] a_sample,
    input  logic [LB+1:0]        a_phase,
    input  logic                 a_quarter,
    input  logic                 a_zero,
    output logic                 b_valid,
    output logic signed [DW-1:0] b_sample,
    output logic signed [AW-1:0] b_cos,
    output logic signed [AW-1:0] b_sin,
    output logic [1:0]           b_quad,
    output logic                 b_quarter,
    output logic                 b_zero
);
    localparam int PB  = LB + 2;
    localparam int ENT = 1 << LB;
    localparam int AMP = (1 << (AW - 1)) - 1;

    logic [AW-2:0] tbl [ENT+1];

    for (genvar k = 0; k <= ENT; k++) begin : g_tbl
        localparam int VAL = cnm_pkg::quarter_sine(k, LB, AMP);
        assign tbl[k] = (AW-1)'(VAL);
    end

    // index 0 gives sine, index 1 gives cosine (phase advanced by a quarter turn)
    logic signed [AW-1:0] amp [2];

    for (genvar g = 0; g < 2; g++) begin : g_wave
        logic [PB-1:0] ph;
        logic [1:0]    quad;
        logic [LB:0]   idx;
        logic [AW-2:0] mag;
        assign ph   = a_phase + PB'(g * ENT);
        assign quad = ph[PB-1:PB-2];
        assign idx  = quad[0] ? ((LB+1)'(ENT) - {1'b0, ph[LB-1:0]}) : {1'b0, ph[LB-1:0]};
        assign mag  = tbl[idx];
        assign amp[g] = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

    typedef struct packed {
        logic                 valid;
        logic signed [DW-1:0] sample;
        logic signed [AW-1:0] cosv;
        logic signed [AW-1:0] sinv;
        logic [1:0]           quad;
        logic                 quarter;
        logic                 zero;
    } sc_st_t;

    sc_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = a_valid;
        if (a_valid) begin
            st_d.sample  = a_sample;
            st_d.cosv    = amp[1];
            st_d.sinv    = amp[0];
            st_d.quad    = a_phase[PB-1:PB-2];
            st_d.quarter = a_quarter;
            st_d.zero    = a_zero;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign b_valid   = st_q.valid;
    assign b_sample  = st_q.sample;
    assign b_cos     = st_q.cosv;
    assign b_sin     = st_q.sinv;
    assign b_quad    = st_q.quad;
    assign b_quarter = st_q.quarter;
    assign b_zero    = st_q.zero;

endmodule

// File: rtl/cnm_product.sv
module cnm_product #(
    parameter int DW = 14,
    parameter int AW = 12,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 b_valid,
    input  logic signed [DW-1:0] b_sample,
    input  logic signed [AW-1:0] b_cos,
    input  logic signed [AW-1:0] b_sin,
    input  logic [1:0]           b_quad,
    input  logic                 b_quarter,
    input  logic                 b_zero,
    output logic                 o_valid,
    output logic signed [OW-1:0] o_i,
    output logic signed [OW-1:0] o_q
);
    localparam int WW   = DW + AW + 1;
    localparam int GAIN = OW - DW;
    localparam int SH   = AW - 1 - GAIN;
    localparam logic signed [WW-1:0] HALF = WW'(1) <<< (SH - 1);

    function automatic logic signed [OW-1:0] clip(input logic signed [WW-1:0] v);
        logic [WW-OW:0] top;
        top = v[WW-1:OW-1];
        if ((&top) || !(|top)) begin
            return v[OW-1:0];
        end
        return v[WW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};
    endfunction

    typedef struct packed {
        logic                 valid;
        logic signed [OW-1:0] ival;
        logic signed [OW-1:0] qval;
    } pr_st_t;

    pr_st_t st_d, st_q;
    logic signed [WW-1:0] xs, nx, pi_w, pq_w, ri, rq, ti, tq, si, sq;

    always_comb begin
        xs   = WW'(b_sample) <<< GAIN;
        nx   = -xs;
        pi_w = WW'(b_sample) * WW'(b_cos);
        pq_w = WW'(b_sample) * WW'(b_sin);
        ri   = (pi_w + HALF) >>> SH;
        rq   = (pq_w + HALF) >>> SH;
        case (b_quad)
            2'd0:    begin ti = xs;     tq = '0;     end
            2'd1:    begin ti = '0;     tq = xs;     end
            2'd2:    begin ti = nx;     tq = '0;     end
            default: begin ti = '0;     tq = nx;     end
        endcase
        if (b_zero) begin
            si = '0;
            sq = '0;
        end else if (b_quarter) begin
            si = ti;
            sq = tq;
        end else begin
            si = ri;
            sq = rq;
        end
        st_d       = st_q;
        st_d.valid = b_valid;
        if (b_valid) begin
            st_d.ival = clip(si);
            st_d.qval = clip(sq);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_valid = st_q.valid;
    assign o_i     = st_q.ival;
    assign o_q     = st_q.qval;

endmodule

// File: rtl/cplx_nco_mixer.sv
module cplx_nco_mixer #(
    parameter int DW = 14,
    parameter int PW = 16,
    parameter int AW = 12,
    parameter int OW = 16,
    parameter int LB = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_valid,
    input  logic signed [DW-1:0] i_sample,
    input  logic [PW-1:0]        i_ftw,
    input  logic [1:0]           i_mode,
    input  logic                 i_quarter_up,
    output logic                 o_valid,
    output logic signed [OW-1:0] o_i,
    output logic signed [OW-1:0] o_q
);
    localparam int PB = LB + 2;
    localparam logic [PW-1:0] QTR = PW'(1) << (PW - 2);

    logic                 a_valid, a_quarter, a_zero;
    logic signed [DW-1:0] a_sample;
    logic [PB-1:0]        a_phase;
    logic                 b_valid, b_quarter, b_zero;
    logic signed [DW-1:0] b_sample;
    logic signed [AW-1:0] b_cos, b_sin;
    logic [1:0]           b_quad;

    cnm_phase_acc #(.DW(DW), .PW(PW), .PB(PB)) u_acc (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_sample(i_sample),
        .i_ftw(i_ftw), .i_mode(i_mode), .i_quarter_up(i_quarter_up),
        .a_valid(a_valid), .a_sample(a_sample), .a_phase(a_phase),
        .a_quarter(a_quarter), .a_zero(a_zero)
    );

    cnm_sincos #(.DW(DW), .AW(AW), .LB(LB)) u_sc (
        .clk(clk), .rst(rst), .a_valid(a_valid), .a_sample(a_sample),
        .a_phase(a_phase), .a_quarter(a_quarter), .a_zero(a_zero),
        .b_valid(b_valid), .b_sample(b_sample), .b_cos(b_cos), .b_sin(b_sin),
        .b_quad(b_quad), .b_quarter(b_quarter), .b_zero(b_zero)
    );

    cnm_product #(.DW(DW), .AW(AW), .OW(OW)) u_prod (
        .clk(clk), .rst(rst), .b_valid(b_valid), .b_sample(b_sample),
        .b_cos(b_cos), .b_sin(b_sin), .b_quad(b_quad), .b_quarter(b_quarter),
        .b_zero(b_zero), .o_valid(o_valid), .o_i(o_i), .o_q(o_q)
    );

    // R2
    out_latency_chk: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> $past(i_valid, 3));

    // R7
    guard_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && $past(i_valid && (i_mode == 2'd2) &&
                          ((i_ftw == QTR) || (i_ftw == 3 * QTR)), 3))
        |-> (o_i == '0 && o_q == '0));

    // R6
    quarter_axis_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && $past(i_valid && (i_mode == 2'd0), 3))
        |-> (o_i == '0 || o_q == '0));

endmodule

// File: tb/cplx_nco_mixer_tb.sv
`timescale 1ns/1ps
module cplx_nco_mixer_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               i_valid = 1'b0;
    logic signed [13:0] i_sample = '0;
    logic [15:0]        i_ftw = '0;
    logic [1:0]         i_mode = '0;
    logic               i_quarter_up = 1'b0;
    logic               o_valid;
    logic signed [15:0] o_i, o_q;

    cplx_nco_mixer u_dut (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_sample(i_sample),
        .i_ftw(i_ftw), .i_mode(i_mode), .i_quarter_up(i_quarter_up),
        .o_valid(o_valid), .o_i(o_i), .o_q(o_q)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int unsigned acc_m = 0;
    bit    pv   [3];
    int    pei  [3];
    int    peq  [3];
    int    ptol [3];
    string preq [3];

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp, input int tol);
        checks++;
        if (act - exp > tol || exp - act > tol) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input int x, input int ftw, input int mode,
                        input bit qup, input string req);
        int ei, eq, tol, stp, qd;
        real th;
        @(negedge clk);
        if (pv[2]) begin
            chk("R2", int'(o_valid), 1, 0);
            chk(preq[2], int'(o_i), pei[2], ptol[2]);
            chk(preq[2], int'(o_q), peq[2], ptol[2]);
        end else begin
            chk("R2", int'(o_valid), 0, 0);
        end
        for (int k = 2; k > 0; k--) begin
            pv[k] = pv[k-1]; pei[k] = pei[k-1]; peq[k] = peq[k-1];
            ptol[k] = ptol[k-1]; preq[k] = preq[k-1];
        end
        i_valid      = v;
        i_sample     = x[13:0];
        i_ftw        = ftw[15:0];
        i_mode       = mode[1:0];
        i_quarter_up = qup;
        ei = 0; eq = 0; tol = 0; stp = ftw;
        if (v) begin
            if (mode == 0) begin
                stp = qup ? 16384 : 49152;
                qd  = int'(acc_m >> 14);
                case (qd)
                    0: ei = sat16(x * 4);
                    1: eq = sat16(x * 4);
                    2: ei = sat16(-x * 4);
                    default: eq = sat16(-x * 4);
                endcase
            end else if (mode == 2 && (ftw == 16384 || ftw == 49152)) begin
                ei = 0; eq = 0;
            end else begin
                th  = 2.0 * 3.14159265358979 * real'((acc_m >> 6) << 6) / 65536.0;
                ei  = sat16(int'(real'(x) * 2047.0 * $cos(th) / 512.0));
                eq  = sat16(int'(real'(x) * 2047.0 * $sin(th) / 512.0));
                tol = 10;
            end
            acc_m = (acc_m + int'(stp)) & 32'hFFFF;
        end
        pv[0] = v; pei[0] = ei; peq[0] = eq; ptol[0] = tol; preq[0] = req;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; i_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1: state after reset
        chk("R1", int'(o_valid), 0, 0);
        chk("R1", int'(o_i), 0, 0);
        chk("R1", int'(o_q), 0, 0);
        rst = 1'b0;
        acc_m = 0;
        for (int k = 0; k < 3; k++) pv[k] = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 0, "R2");
    endtask

    function automatic int rnd_x();
        return int'($urandom % 16384) - 8192;
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        finish_run();
    end

    initial begin
        int ftw, md;
        bit prev_idle;
        void'($urandom(32'd2024));
        for (int k = 0; k < 3; k++) pv[k] = 1'b0;

        // R1: first samples at phase zero
        do_reset();
        step(1, 1000, 0, 1, 0, "R1");
        step(1, -3000, 0, 1, 0, "R1");
        step(1, 8191, 0, 1, 0, "R1");
        step(1, -8192, 0, 1, 0, "R1");
        drain();

        // R3, R4, R5: random oscillator runs with gaps and retuning
        do_reset();
        ftw = int'($urandom % 65536);
        prev_idle = 0;
        for (int n = 0; n < 400; n++) begin
            bit v;
            string rq;
            rq = "R3";
            md = ($urandom % 2 == 0) ? 1 : 3;
            if (n % 40 == 39) begin
                ftw = int'($urandom % 65536);
                rq = "R5";
            end else if (prev_idle) begin
                rq = "R4";
            end
            v = ($urandom % 4) != 0;
            step(v, rnd_x(), ftw, md, 0, rq);
            prev_idle = !v;
        end
        drain();

        // R4: wrap-around with steps crossing zero
        do_reset();
        for (int n = 0; n < 20; n++) step(1, rnd_x(), 65535, 1, 0, "R4");
        for (int n = 0; n < 60; n++) step(1, rnd_x(), 40000, 1, 0, "R4");
        drain();

        // R6: quarter-rate, both directions
        do_reset();
        for (int n = 0; n < 12; n++) step(1, rnd_x(), 0, 0, 0, "R6");
        drain();
        do_reset();
        for (int n = 0; n < 12; n++) step(1, rnd_x(), 0, 0, 1, "R6");
        drain();

        // R8: full-scale negative sample against coefficient -1
        do_reset();
        step(1, -8192, 0, 0, 0, "R8");
        step(1, 5, 0, 0, 0, "R8");
        step(1, -8192, 0, 0, 0, "R8");
        step(1, -8192, 0, 0, 0, "R8");
        step(1, 8191, 0, 0, 0, "R8");
        drain();

        // R7: forbidden words zeroed, neighbour word normal, phase continues
        do_reset();
        for (int n = 0; n < 10; n++) step(1, rnd_x(), 16384, 2, 0, "R7");
        for (int n = 0; n < 10; n++) step(1, rnd_x(), 49152, 2, 0, "R7");
        for (int n = 0; n < 10; n++) step(1, rnd_x(), 16385, 2, 0, "R7");
        for (int n = 0; n < 10; n++) step(1, rnd_x(), 1000, 1, 0, "R7");
        drain();

        finish_run();
    end

endmodule